// File: doc/BRIEF.md
# Interrupt Pending and In-Service Register

This block keeps two flags for each of six interrupt sources: a pending flag, which means the source has asked for attention, and an in-service flag, which means a handler for that source is running. The sources are receive status, receive data, transmit status, transmit data, I/O pin and miscellaneous. Software never writes the flag values directly. Each 16-bit bus write instead carries two command fields, and each command acts only on the sources that its 6-bit select mask names. One command can set or clear in-service flags. The other can set pending flags, clear them, or clear the pending and in-service flags of the selected sources together.

Peripheral event lines also set pending flags. The block compares every pending flag against the in-service flags under a fixed priority and raises an interrupt request when some pending source is not blocked. An acknowledge pulse moves the winning source from pending to in-service. All flag state is held in registers. A write, an event or an acknowledge that is present at a rising clock edge shows up on the read port after that edge.

Top module: `intr_svc_reg`

## Requirements
- R1: The read word holds the in-service flags in bits 13:8 and the pending flags in bits 5:0. In each group the order from the high bit down is receive status, receive data, transmit status, transmit data, I/O pin, miscellaneous. Bits 15:14 and 7:6 always read 0.
- R2: The in-service command sits in write bits 15:14 and its mask in bits 13:8. Code 10 clears the selected in-service flags, code 11 sets them, and codes 00 and 01 do nothing.
- R3: The pending command sits in write bits 7:6 and its mask in bits 5:0. Code 10 clears the selected pending flags, code 11 sets them, and code 00 does nothing.
- R4: Pending command 01 clears both the pending flag and the in-service flag of each selected source. If the same write also sets in-service flags for those sources, the clear wins.
- R5: A source whose mask bit is 0 keeps both of its flags, whatever command code is written.
- R6: A high level on bit i of the event input sets pending flag i at the next clock edge. It wins over a software clear of the same flag at that edge.
- R7: The interrupt request is high exactly when some source is pending and no source of equal or higher priority is in service. Priority is fixed, with receive status (bit 5) highest and miscellaneous (bit 0) lowest.
- R8: An acknowledge pulse sets the in-service flag and clears the pending flag of the highest-priority eligible source. When no source is eligible, the acknowledge has no effect.
- R9: Reset clears every pending and in-service flag and drops the interrupt request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Command write strobe |
| wrData | input | 16 | Command word (two op-codes with their masks) |
| evtIn | input | 6 | Per-source event lines that set pending flags |
| ackPulse | input | 1 | Interrupt acknowledge |
| rdData | output | 16 | Current flag state in read format |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench goes after a set of same-edge conflicts:
- An event meeting a software clear of the same flag. A design that lets the clear win loses the interrupt.
- A clear-both command arriving together with an in-service set. Getting this wrong leaves a handler flagged as running after software retired it.
- Command codes 00 and 01 on the in-service field, written with full masks. A design that reads only one op-code bit would wrongly set or clear flags here.
- An acknowledge when every pending source is blocked. A design that grants blindly would corrupt the in-service mask.

Randomized command words, events and acknowledges are compared cycle by cycle against a reference model. This shows up wrong field positions, a reversed priority order and a request that ignores higher in-service flags.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int SRC_CNT = 6;
  localparam int OP_W    = 2;
  localparam int GRP_W   = SRC_CNT + OP_W;
  localparam int WORD_W  = 2 * GRP_W;

  typedef logic [SRC_CNT-1:0] srcVec_t;

  // per-source strobes from control to datapath
  typedef struct packed {
    srcVec_t ipSet;
    srcVec_t ipClr;
    srcVec_t iusSet;
    srcVec_t iusClr;
  } isrStrobe_t;

  typedef enum logic [OP_W-1:0] {
    IUS_NOP0 = 2'b00,
    IUS_NOP1 = 2'b01,
    IUS_CLR  = 2'b10,
    IUS_SET  = 2'b11
  } iusOp_e;

  typedef enum logic [OP_W-1:0] {
    IP_NOP     = 2'b00,
    IP_CLRBOTH = 2'b01,
    IP_CLR     = 2'b10,
    IP_SET     = 2'b11
  } ipOp_e;
endpackage

// File: rtl/isr_prio.sv
module isr_prio
  import isr_pkg::*;
(
  input  srcVec_t ipQ,
  input  srcVec_t iusQ,
  output srcVec_t grant,
  output logic    irq
);
  srcVec_t elig;

  // a source is eligible when pending and nothing at or above it is in service
  always_comb begin
    logic covered;
    covered = 1'b0;
    for (int i = SRC_CNT - 1; i >= 0; i--) begin
      covered = covered | iusQ[i];
      elig[i] = ipQ[i] & ~covered;
    end
  end

  // highest eligible source wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int i = SRC_CNT - 1; i >= 0; i--) begin
      grant[i] = elig[i] & ~taken;
      taken    = taken | elig[i];
    end
  end

  assign irq = |elig;
endmodule

// File: rtl/isr_ctrl.sv
module isr_ctrl
  import isr_pkg::*;
(
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              ackPulse,
  input  srcVec_t           grant,
  output isrStrobe_t        strb
);
  iusOp_e  iusOp;
  ipOp_e   ipOp;
  srcVec_t iusMask;
  srcVec_t ipMask;

  assign iusOp   = iusOp_e'(wrData[WORD_W-1 -: OP_W]);
  assign iusMask = wrData[GRP_W +: SRC_CNT];
  assign ipOp    = ipOp_e'(wrData[GRP_W-1 -: OP_W]);
  assign ipMask  = wrData[SRC_CNT-1:0];

  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (iusOp)
        IUS_CLR: strb.iusClr = strb.iusClr | iusMask;
        IUS_SET: strb.iusSet = strb.iusSet | iusMask;
        default: ;
      endcase
      case (ipOp)
        IP_CLRBOTH: begin
          strb.ipClr  = strb.ipClr | ipMask;
          strb.iusClr = strb.iusClr | ipMask;
        end
        IP_CLR:  strb.ipClr = strb.ipClr | ipMask;
        IP_SET:  strb.ipSet = strb.ipSet | ipMask;
        default: ;
      endcase
    end
    if (ackPulse) begin
      strb.iusSet = strb.iusSet | grant;
      strb.ipClr  = strb.ipClr | grant;
    end
  end
endmodule

// File: rtl/isr_data.sv
module isr_data
  import isr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  isrStrobe_t        strb,
  input  srcVec_t           evtIn,
  output srcVec_t           ipQ,
  output srcVec_t           iusQ,
  output logic [WORD_W-1:0] rdData
);
  srcVec_t ipNext;
  srcVec_t iusNext;

  // clears win over sets for in-service; events and sets win over clears for pending
  assign iusNext = (iusQ | strb.iusSet) & ~strb.iusClr;
  assign ipNext  = (ipQ & ~strb.ipClr) | strb.ipSet | evtIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ipQ  <= '0;
      iusQ <= '0;
    end else begin
      ipQ  <= ipNext;
      iusQ <= iusNext;
    end
  end

  assign rdData = {{OP_W{1'b0}}, iusQ, {OP_W{1'b0}}, ipQ};
endmodule

// File: rtl/intr_svc_reg.sv
module intr_svc_reg
  import isr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic [SRC_CNT-1:0] evtIn,
  input  logic              ackPulse,
  output logic [WORD_W-1:0] rdData,
  output logic              irqOut
);
  isrStrobe_t strb;
  srcVec_t    ipQ;
  srcVec_t    iusQ;
  srcVec_t    grant;

  isr_ctrl u_ctrl (
    .wrEn(wrEn), .wrData(wrData), .ackPulse(ackPulse),
    .grant(grant), .strb(strb)
  );

  isr_data u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .evtIn(evtIn),
    .ipQ(ipQ), .iusQ(iusQ), .rdData(rdData)
  );

  isr_prio u_prio (
    .ipQ(ipQ), .iusQ(iusQ), .grant(grant), .irq(irqOut)
  );
endmodule

// File: rtl/isr_checker.sv
module isr_checker
  import isr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [WORD_W-1:0] wrData,
  input logic [SRC_CNT-1:0] evtIn,
  input logic              ackPulse,
  input logic [WORD_W-1:0] rdData,
  input logic              irqOut
);
  // R1: op-code positions never read back
  assert_opbits_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    rdData[WORD_W-1 -: OP_W] == '0 && rdData[GRP_W-1 -: OP_W] == '0);

  // R6: an event always leaves its pending flag set
  assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    evtIn != '0 |=> (rdData[SRC_CNT-1:0] & $past(evtIn)) == $past(evtIn));

  // R4: clear-both leaves selected in-service flags clear
  assert_clear_both_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[GRP_W-1 -: OP_W] == 2'b01)
      |=> (rdData[GRP_W +: SRC_CNT] & $past(wrData[SRC_CNT-1:0])) == '0);

  // R7: a request needs at least one pending source
  assert_irq_needs_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> rdData[SRC_CNT-1:0] != '0);

  // R5: with no stimulus the state holds
  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !ackPulse && evtIn == '0) |=> $stable(rdData));

  // R8: an acknowledge never removes in-service flags
  assert_ack_keeps_ius_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ackPulse && !wrEn) |=> (rdData[GRP_W +: SRC_CNT] & $past(rdData[GRP_W +: SRC_CNT]))
                             == $past(rdData[GRP_W +: SRC_CNT]));
endmodule

bind intr_svc_reg isr_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .evtIn(evtIn),
  .ackPulse(ackPulse), .rdData(rdData), .irqOut(irqOut)
);

// File: tb/intr_svc_reg_bench.sv
`timescale 1ns/1ps
module intr_svc_reg_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [5:0]  evtIn = '0;
  logic        ackPulse = 1'b0;
  logic [15:0] rdData;
  logic        irqOut;

  int vecs = 0;
  int errs = 0;
  logic [5:0] mIp = '0;
  logic [5:0] mIus = '0;

  always #2.5 clk = ~clk;

  intr_svc_reg u_intr_svc_reg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .evtIn(evtIn),
    .ackPulse(ackPulse), .rdData(rdData), .irqOut(irqOut)
  );

  function automatic logic [5:0] eligOf(input logic [5:0] ip, input logic [5:0] ius);
    logic [5:0] e;
    logic blk;
    blk = 1'b0;
    for (int i = 5; i >= 0; i--) begin
      if (ius[i]) blk = 1'b1;
      e[i] = ip[i] && !blk;
    end
    return e;
  endfunction

  function automatic logic [5:0] topOf(input logic [5:0] e);
    for (int i = 5; i >= 0; i--) if (e[i]) return 6'(1 << i);
    return 6'd0;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h, want %h", req, act, exp);
    end
  endtask

  // drive after a falling edge, compare after the next falling edge
  task automatic step(input logic w, input logic [15:0] d, input logic [5:0] e,
                      input logic a, input string req);
    logic [5:0] ipS, ipC, iuS, iuC, g;
    ipS = 0; ipC = 0; iuS = 0; iuC = 0;
    if (w) begin
      if (d[15:14] == 2'b10) iuC |= d[13:8];
      if (d[15:14] == 2'b11) iuS |= d[13:8];
      if (d[7:6] == 2'b01) begin ipC |= d[5:0]; iuC |= d[5:0]; end
      if (d[7:6] == 2'b10) ipC |= d[5:0];
      if (d[7:6] == 2'b11) ipS |= d[5:0];
    end
    if (a) begin
      g = topOf(eligOf(mIp, mIus));
      iuS |= g;
      ipC |= g;
    end
    wrEn = w; wrData = d; evtIn = e; ackPulse = a;
    @(negedge clk);
    mIus = (mIus | iuS) & ~iuC;
    mIp  = (mIp & ~ipC) | ipS | e;
    check(req, rdData, {2'b00, mIus, 2'b00, mIp});
    check({req, " R7 irq"}, {15'd0, irqOut}, {15'd0, |eligOf(mIp, mIus)});
    wrEn = 0; wrData = '0; evtIn = '0; ackPulse = 0;
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    mIp = '0; mIus = '0;
    check("R9 reset flags", rdData, 16'h0000);
    check("R9 reset irq", {15'd0, irqOut}, 16'h0000);
  endtask

  initial begin
    #500000;
    errs++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    doReset();
    step(1, 16'h00FF, 0, 0, "R3 set all pending");
    step(0, 16'h0000, 0, 1, "R8 ack highest");
    step(1, 16'hA000, 0, 0, "R2 clear in-service");
    step(0, 16'h0000, 0, 1, "R8 ack again");
    step(0, 16'h0000, 0, 1, "R8 ack nested");
    step(1, {2'b11, 6'h3F, 2'b01, 6'h0C}, 0, 0, "R4 clear-both beats set");
    step(1, {2'b01, 6'h3F, 2'b00, 6'h3F}, 0, 0, "R5 nop codes full mask");
    step(1, {2'b00, 6'h3F, 2'b00, 6'h00}, 0, 0, "R5 nop code zero");
    step(1, {2'b11, 6'h00, 2'b10, 6'h00}, 0, 0, "R5 zero masks");
    step(1, {2'b00, 6'h00, 2'b10, 6'h3F}, 6'h05, 0, "R6 event beats clear");
    step(1, {2'b11, 6'h3F, 2'b11, 6'h3F}, 0, 0, "R1 all flags set");
    step(0, 16'h0000, 0, 1, "R8 ack none eligible");
    step(1, {2'b10, 6'h30, 2'b00, 6'h00}, 0, 0, "R7 unblock low");
    for (int n = 0; n < 600; n++) begin
      logic w, a;
      logic [15:0] d;
      logic [5:0] e;
      w = ($urandom % 2) == 0;
      d = 16'($urandom);
      e = (($urandom % 4) == 0) ? 6'($urandom) : 6'd0;
      a = ($urandom % 3) == 0;
      step(w, d, e, a, "R1 random");
    end
    step(1, 16'hFFFF, 0, 0, "R3 fill before reset");
    doReset();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule